// File: doc/BRIEF.md
# Grouped Synchronous Clock Output Gate

This block fans one reference clock out to six gated copies. Two enable inputs arrive with no timing relation to the reference clock. The first enable opens or closes a group of five outputs (lanes 0 to 4) together. The second enable controls lane 5 on its own. A disabled lane is parked at logic low.

Each enable passes through a synchronizer clocked on the falling edge of the reference. The gating level can therefore change only while the reference is low. Each lane is the AND of the reference with its group's synchronized enable, so a lane either carries complete reference pulses or stays low, and never produces a runt or a shortened pulse. The synchronizer depth is set so that an enable change reaches the outputs after a fixed number of reference cycles. The block suits a clock distribution point where whole branches of the clock tree are switched on and off during operation.

Top module: `grouped_clk_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` is 0, whatever the enables are. Asserting `rst_n` low while the reference is high drives the outputs low at once. After `rst_n` rises, the outputs stay low until the enables have crossed the full synchronizer.
- R2: `en_grp_a` gates bits 0 to 4 of `clk_out` together, and those five bits always carry the same value. Changing it has no effect on bit 5.
- R3: `en_grp_b` gates only bit 5 of `clk_out`. Changing it has no effect on bits 0 to 4.
- R4: With both enables high, all six bits toggle at the reference frequency. With both enables low, all six bits are held at 0.
- R5: Suppose an enable rises after a reference rising edge and before the next falling edge. The first gated high pulse then begins at the 4th reference rising edge after the change (START_LATENCY = 4).
- R6: Suppose an enable falls after a reference rising edge and before the next falling edge. The pulse at the 4th reference rising edge after the change is the first one suppressed, and every earlier pulse is whole.
- R7: No bit of `clk_out` is ever high while `clk_ref` is low.
- R8: Every high pulse on a lane lasts exactly as long as the high phase of the reference. The only exception is a pulse cut short by an asynchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that is distributed to the lanes |
| rst_n | input | 1 | Active-low asynchronous reset; clears both synchronizers |
| en_grp_a | input | 1 | Asynchronous enable for lanes 0 to 4 |
| en_grp_b | input | 1 | Asynchronous enable for lane 5 |
| clk_out | output | 6 | Gated copies of the reference, one per lane |

## Verification
The bound checker evaluates several properties on every cycle: the outputs are low during the low phase of the reference, the five group lanes stay coherent, the outputs are zero under reset, and each lane matches its enable delayed by the synchronizer depth at every falling edge. Only the bench scenarios can show the exact rising-edge count from an enable change to the first or last pulse. The same holds for the immediate drop on a mid-pulse reset and the high-time of each pulse, which is measured in simulated time. The bench also shows that switching one group leaves the other untouched, across a sequence of enable combinations.

// File: rtl/grouped_clk_gate_pkg.sv
package grouped_clk_gate_pkg;

   // Number of independent gating groups served by the block.
   localparam int unsigned NUM_GROUPS = 2;

   // Index of the group that owns a given lane: lanes below the split
   // belong to group 0, the remaining lanes to group 1.
   function automatic int unsigned lane_owner(input int unsigned lane,
                                              input int unsigned split);
      return (lane < split) ? 0 : 1;
   endfunction

endpackage

// File: rtl/cg_fall_sync.sv
// Falling-edge synchronizer: the output can only change while the
// reference clock is low. Depth chosen by parameter.
module cg_fall_sync #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("cg_fall_sync: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic stage_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= async_in;
         end
         assign sync_out = stage_q;
      end else begin : g_chain
         logic [DEPTH-1:0] chain_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[DEPTH-2:0], async_in};
         end
         assign sync_out = chain_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/cg_lane_array.sv
// Combines the reference with each lane's group gate.
module cg_lane_array
   import grouped_clk_gate_pkg::*;
#(
   parameter int unsigned LANES = 6,
   parameter int unsigned SPLIT = 5
) (
   input  logic                  clk,
   input  logic [NUM_GROUPS-1:0] gate_lvl,
   output logic [LANES-1:0]      lane_clk
);

   generate
      for (genvar li = 0; li < LANES; li++) begin : g_lane
         localparam int unsigned OWNER = lane_owner(li, SPLIT);
         // gate_lvl only moves on falling edges, so the AND is glitch free
         assign lane_clk[li] = clk & gate_lvl[OWNER];
      end
   endgenerate

endmodule

// File: rtl/grouped_clk_gate.sv
module grouped_clk_gate
   import grouped_clk_gate_pkg::*;
#(
   parameter int unsigned NUM_LANES     = 6,
   parameter int unsigned GRP_A_LANES   = 5,
   parameter int unsigned START_LATENCY = 4
) (
   input  logic                 clk_ref,
   input  logic                 rst_n,
   input  logic                 en_grp_a,
   input  logic                 en_grp_b,
   output logic [NUM_LANES-1:0] clk_out
);

   // Falling-edge stages needed so the first gated rising edge is the
   // START_LATENCY-th reference rising edge after an enable change.
   localparam int unsigned SYNC_DEPTH = START_LATENCY;

   generate
      if (GRP_A_LANES < 1 || GRP_A_LANES >= NUM_LANES) begin : g_bad_split
         $error("grouped_clk_gate: GRP_A_LANES must leave both groups non-empty");
      end
      if (START_LATENCY < 1) begin : g_bad_lat
         $error("grouped_clk_gate: START_LATENCY must be at least 1");
      end
   endgenerate

   logic [NUM_GROUPS-1:0] en_raw;
   logic [NUM_GROUPS-1:0] gate_lvl;

   assign en_raw = {en_grp_b, en_grp_a};

   generate
      for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
         cg_fall_sync #(
            .DEPTH(SYNC_DEPTH)
         ) u_sync (
            .clk      (clk_ref),
            .rst_n    (rst_n),
            .async_in (en_raw[gi]),
            .sync_out (gate_lvl[gi])
         );
      end
   endgenerate

   cg_lane_array #(
      .LANES(NUM_LANES),
      .SPLIT(GRP_A_LANES)
   ) u_lanes (
      .clk      (clk_ref),
      .gate_lvl (gate_lvl),
      .lane_clk (clk_out)
   );

endmodule

// File: rtl/grouped_clk_gate_chk.sv
module grouped_clk_gate_chk #(
   parameter int unsigned NUM_LANES     = 6,
   parameter int unsigned GRP_A_LANES   = 5,
   parameter int unsigned START_LATENCY = 4
) (
   input logic                 clk_ref,
   input logic                 rst_n,
   input logic                 en_grp_a,
   input logic                 en_grp_b,
   input logic [NUM_LANES-1:0] clk_out
);

   localparam int unsigned NB = NUM_LANES - GRP_A_LANES;

   // Delay line of the enables, sampled on falling edges, as the
   // independent latency reference.
   logic [START_LATENCY-1:0] hist_a;
   logic [START_LATENCY-1:0] hist_b;

   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         hist_a <= '0;
         hist_b <= '0;
      end else begin
         hist_a[0] <= en_grp_a;
         hist_b[0] <= en_grp_b;
         for (int k = 1; k < START_LATENCY; k++) begin
            hist_a[k] <= hist_a[k-1];
            hist_b[k] <= hist_b[k-1];
         end
      end
   end

   // R1: outputs parked low throughout reset
   always @(negedge clk_ref) begin
      if (!rst_n) begin
         a_r1_reset_low: assert (clk_out == '0)
            else $error("R1: output high during reset");
      end
   end

   // R7: nothing high during the low phase of the reference
   a_r7_low_phase: assert property (@(posedge clk_ref) disable iff (!rst_n)
      clk_out == '0);

   // R2: group A lanes move together
   a_r2_group_coherent: assert property (@(negedge clk_ref) disable iff (!rst_n)
      (clk_out[GRP_A_LANES-1:0] == '0) || (clk_out[GRP_A_LANES-1:0] == '1));

   // R2, R5, R6: group A follows its enable after the synchronizer depth
   a_r2_group_a_latency: assert property (@(negedge clk_ref) disable iff (!rst_n)
      clk_out[GRP_A_LANES-1:0] == {GRP_A_LANES{hist_a[START_LATENCY-1]}});

   // R3, R5, R6: group B follows its own enable only
   a_r3_group_b_latency: assert property (@(negedge clk_ref) disable iff (!rst_n)
      clk_out[NUM_LANES-1:GRP_A_LANES] == {NB{hist_b[START_LATENCY-1]}});

endmodule

bind grouped_clk_gate grouped_clk_gate_chk #(
   .NUM_LANES     (NUM_LANES),
   .GRP_A_LANES   (GRP_A_LANES),
   .START_LATENCY (START_LATENCY)
) u_chk (
   .clk_ref  (clk_ref),
   .rst_n    (rst_n),
   .en_grp_a (en_grp_a),
   .en_grp_b (en_grp_b),
   .clk_out  (clk_out)
);

// File: tb/sim_grouped_clk_gate.sv
`timescale 1ns/1ps
module sim_grouped_clk_gate;

   localparam real CLK_PERIOD = 10.0;
   localparam real HALF       = CLK_PERIOD / 2.0;
   localparam int  LAT        = 4;

   logic       clk_ref = 1'b0;
   logic       rst_n   = 1'b0;
   logic       en_grp_a = 1'b0;
   logic       en_grp_b = 1'b0;
   logic [5:0] clk_out;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;

   grouped_clk_gate u0 (
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .en_grp_a (en_grp_a),
      .en_grp_b (en_grp_b),
      .clk_out  (clk_out)
   );

   always #(HALF) clk_ref = ~clk_ref;

   // scoreboard queues: cycle at which the new pattern appears
   int         q_at[$];
   logic [5:0] q_mask[$];
   string      q_req[$];

   logic [5:0] exp_now = 6'h00;
   string      cur_req = "R1";

   task automatic chk(input bit ok, input string req,
                      input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: clk_out=%b expected=%b", req, cyc, act, exp);
      end
   endtask

   function automatic logic [5:0] mask_of(input logic a, input logic b);
      return {b, {5{a}}};
   endfunction

   // driver: change enables right after a rising edge, push expectation
   task automatic apply(input logic a, input logic b, input string req);
      @(posedge clk_ref);
      #1;
      q_at.push_back(cyc + LAT);
      q_mask.push_back(mask_of(a, b));
      q_req.push_back(req);
      en_grp_a = a;
      en_grp_b = b;
      repeat (8) @(posedge clk_ref);
   endtask

   task automatic release_reset(input string req);
      @(posedge clk_ref);
      #1;
      rst_n = 1'b1;
      q_at.push_back(cyc + LAT);
      q_mask.push_back(mask_of(en_grp_a, en_grp_b));
      q_req.push_back(req);
      repeat (8) @(posedge clk_ref);
   endtask

   // monitor: sample during the high phase of the reference
   always @(posedge clk_ref) begin
      cyc = cyc + 1;
      #1;
      if (!rst_n) exp_now = 6'h00;
      if (q_at.size() > 0 && cyc == q_at[0]) begin
         exp_now = q_mask.pop_front();
         cur_req = q_req.pop_front();
         void'(q_at.pop_front());
      end
      chk(clk_out == exp_now, cur_req, clk_out, exp_now);
   end

   // R7: low phase of the reference
   always @(negedge clk_ref) begin
      #1;
      chk(clk_out == 6'h00, "R7", clk_out, 6'h00);
   end

   // R8: pulse width on a group A lane and on lane 5
   always begin
      realtime t0;
      @(posedge clk_out[0]);
      t0 = $realtime;
      @(negedge clk_out[0]);
      if (rst_n) begin
         checks++;
         if ($realtime - t0 != HALF) begin
            errors++;
            $display("FAIL R8 lane0 high time=%0t expected=%0t", $realtime - t0, HALF);
         end
      end
   end

   always begin
      realtime t5;
      @(posedge clk_out[5]);
      t5 = $realtime;
      @(negedge clk_out[5]);
      if (rst_n) begin
         checks++;
         if ($realtime - t5 != HALF) begin
            errors++;
            $display("FAIL R8 lane5 high time=%0t expected=%0t", $realtime - t5, HALF);
         end
      end
   end

   initial begin
      // R1: enables high during reset must not reach the outputs
      en_grp_a = 1'b1;
      en_grp_b = 1'b1;
      repeat (4) @(posedge clk_ref);
      release_reset("R5");                 // all lanes start after LAT edges
      apply(1'b0, 1'b1, "R6");             // group A stops, R2: lane 5 keeps going
      apply(1'b0, 1'b0, "R3");             // lane 5 stops alone
      apply(1'b1, 1'b0, "R2");             // group A starts, lane 5 stays low
      apply(1'b1, 1'b1, "R4");             // all six toggle
      apply(1'b0, 1'b0, "R4");             // both stop together
      apply(1'b0, 1'b1, "R3");             // lane 5 starts alone
      apply(1'b1, 1'b1, "R5");             // group A joins
      // R1: reset in the middle of a high phase drops outputs at once
      @(posedge clk_ref);
      #2;
      rst_n = 1'b0;
      #1;
      chk(clk_out == 6'h00, "R1", clk_out, 6'h00);
      repeat (3) @(posedge clk_ref);
      release_reset("R1");
      apply(1'b0, 1'b0, "R6");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at cycle %0d: clk_out=%b expected=done", cyc, clk_out);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule